// File: doc/BRIEF.md
# Command Frame CRC7 Unit

This block protects the 48-bit command and response frames of a serial card bus with a 7-bit cyclic redundancy code. The generator polynomial is x^7 + x^3 + 1. The code covers the 40 leading frame bits, from the start bit up to the last payload bit, and is the remainder of that message times x^7 divided by the polynomial. The unit only detects errors. It reports a mismatch and leaves recovery to the host, which normally repeats the command.

A frame begins with a one-cycle `start_i` pulse while the unit is idle. `mode_i` is sampled with that pulse and then held for the whole frame: 0 selects check, 1 selects generate. Serial bits are taken most significant first, one per clock in which `bit_valid_i` is high. The first bit is taken at the earliest in the cycle after the start pulse.

- **Check mode.** The unit accumulates the CRC over 40 bits. It then shifts in the 7 received CRC bits and accepts the end bit. After that 48th bit it gives a one-cycle `done_o` together with either `crc_ok_o` or `crc_err_o`.
- **Generate mode.** Each accepted payload bit is echoed on `tx_bit_o`/`tx_valid_o` one cycle later. On the consecutive cycles that follow, the unit sends the 7 CRC bits, most significant first, and then a constant 1 end bit. `done_o` is raised in the end-bit cycle.

The states are:

- `ST_IDLE`
- `ST_CHK_DATA` and `ST_CHK_CRC` and `ST_CHK_END` (check mode)
- `ST_GEN_DATA` and `ST_GEN_CRC` and `ST_GEN_END` (generate mode)

The transitions are:

- `ST_IDLE` goes to `ST_CHK_DATA` or `ST_GEN_DATA` on start, chosen by the mode.
- The data states go to `ST_CHK_CRC` or `ST_GEN_CRC` on the 40th accepted bit.
- `ST_CHK_CRC` goes to `ST_CHK_END` on the 7th received CRC bit.
- `ST_CHK_END` goes to `ST_IDLE` when the end bit is accepted.
- `ST_GEN_CRC` goes to `ST_GEN_END` after 7 cycles.
- `ST_GEN_END` goes to `ST_IDLE` unconditionally.
- `abort_i` forces `ST_IDLE` from any state.

Top module: `cmd_crc7_unit`

## Requirements
- R1: The CRC equals the remainder of (40-bit message × x^7) divided by x^7 + x^3 + 1, with the first frame bit as the x^39 coefficient.
- R2: Serial bits are consumed only in cycles where `bit_valid_i` is 1. Idle gaps between bits do not change the result.
- R3: In generate mode (`mode_i`=1) the output stream is 48 bits long. It holds the 40 payload bits in order, each valid one cycle after it is accepted. Next come the 7 CRC bits, most significant first, on back-to-back cycles. Last comes an end bit of value 1.
- R4: In check mode (`mode_i`=0) a matching received CRC gives a one-cycle `done_o` with `crc_ok_o`=1. This happens in the cycle after the 48th accepted bit.
- R5: A CRC mismatch in check mode gives `done_o` with `crc_err_o`=1 and `crc_ok_o`=0. `crc_ok_o` and `crc_err_o` are never 1 together.
- R6: In check mode the value of the end bit has no effect on the result.
- R7: `abort_i` returns the unit to idle and clears the CRC register. It raises no `done_o`, no status and no further transmit bits.
- R8: `start_i` and `mode_i` are ignored while a frame is in progress. Each new frame starts from a cleared register.
- R9: After reset, `tx_valid_o`, `tx_bit_o`, `done_o`, `crc_ok_o` and `crc_err_o` are all 0.
- R10: `done_o` lasts exactly one cycle per frame. In generate mode `crc_ok_o` and `crc_err_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start pulse; honoured only in idle |
| mode_i | input | 1 | 0 = check, 1 = generate; sampled with start |
| abort_i | input | 1 | Return to idle and clear, no status |
| bit_valid_i | input | 1 | Serial input bit strobe |
| bit_i | input | 1 | Serial input bit, MSB first |
| tx_valid_o | output | 1 | Transmit bit valid (generate mode) |
| tx_bit_o | output | 1 | Transmit bit: payload, CRC, then end bit |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| crc_ok_o | output | 1 | Received CRC matched (with done) |
| crc_err_o | output | 1 | Received CRC mismatched (with done) |

## Verification
The hardest condition to reach from the ports is an abort that arrives while the unit is sending the CRC tail of a generated frame. No input strobe is involved there, so the window lasts only seven cycles after the 40th payload bit. The bench counts cycles from that bit and asserts `abort_i` inside the window. It then confirms that the transmit stream stops and that no done appears. Mid-frame start pulses with a flipped mode, and end bits of value 0, are injected between strobed bits to show that neither disturbs a frame already under way.

// File: rtl/crc7_pkg.sv
package crc7_pkg;
    localparam int unsigned CRC7_WIDTH    = 7;
    localparam int unsigned CRC7_MSG_BITS = 40;
    localparam logic [6:0]  CRC7_TAPS     = 7'h09; // x^3 + 1, x^7 implied

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK_DATA,
        ST_CHK_CRC,
        ST_CHK_END,
        ST_GEN_DATA,
        ST_GEN_CRC,
        ST_GEN_END
    } crc7_state_e;
endpackage

// File: rtl/crc7_lfsr.sv
module crc7_lfsr #(
    parameter int unsigned WIDTH = 7,
    parameter logic [WIDTH-1:0] TAPS = 7'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             upd_i,
    input  logic             din_i,
    input  logic             shout_i,
    output logic [WIDTH-1:0] crc_o
);
    logic [WIDTH-1:0] crc_q;
    logic [WIDTH-1:0] upd_val;
    logic             fb;

    assign fb = din_i ^ crc_q[WIDTH-1];

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_tap
            if (i == 0) begin : g_lsb
                assign upd_val[i] = TAPS[i] & fb;
            end else begin : g_up
                assign upd_val[i] = crc_q[i-1] ^ (TAPS[i] & fb);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr_i) begin
            crc_q <= '0;
        end else if (upd_i) begin
            crc_q <= upd_val;
        end else if (shout_i) begin
            crc_q <= {crc_q[WIDTH-2:0], 1'b0};
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/crc7_rx_capture.sv
module crc7_rx_capture #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] value_o
);
    logic [WIDTH-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clr_i) begin
            sh_q <= '0;
        end else if (en_i) begin
            sh_q <= {sh_q[WIDTH-2:0], din_i};
        end
    end

    assign value_o = sh_q;
endmodule

// File: rtl/crc7_bit_counter.sv
module crc7_bit_counter #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] cnt_o
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cmd_crc7_unit.sv
module cmd_crc7_unit
    import crc7_pkg::*;
#(
    parameter int unsigned MSG_BITS = CRC7_MSG_BITS,
    parameter int unsigned CRC_W    = CRC7_WIDTH,
    parameter logic [CRC_W-1:0] TAPS = CRC7_TAPS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mode_i,
    input  logic abort_i,
    input  logic bit_valid_i,
    input  logic bit_i,
    output logic tx_valid_o,
    output logic tx_bit_o,
    output logic done_o,
    output logic crc_ok_o,
    output logic crc_err_o
);
    localparam int unsigned CNT_MAX = (MSG_BITS > CRC_W) ? MSG_BITS : CRC_W;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(MSG_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(CRC_W - 1);

    crc7_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic [CRC_W-1:0] crc_calc;
    logic [CRC_W-1:0] crc_rx;
    logic             frame_go;
    logic             step;
    logic             cnt_clr;
    logic             crc_upd;
    logic             crc_shout;
    logic             rx_en;

    assign frame_go = (state_q == ST_IDLE) && start_i;

    // step: an event that advances the position inside the current state
    always_comb begin
        unique case (state_q)
            ST_CHK_DATA, ST_CHK_CRC, ST_CHK_END,
            ST_GEN_DATA: step = bit_valid_i;
            ST_GEN_CRC,
            ST_GEN_END:  step = 1'b1;
            default:     step = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = mode_i ? ST_GEN_DATA : ST_CHK_DATA;
            end
            ST_CHK_DATA: begin
                if (step && cnt == LAST_DATA) state_d = ST_CHK_CRC;
            end
            ST_CHK_CRC: begin
                if (step && cnt == LAST_CRC) state_d = ST_CHK_END;
            end
            ST_CHK_END: begin
                if (step) state_d = ST_IDLE;
            end
            ST_GEN_DATA: begin
                if (step && cnt == LAST_DATA) state_d = ST_GEN_CRC;
            end
            ST_GEN_CRC: begin
                if (cnt == LAST_CRC) state_d = ST_GEN_END;
            end
            ST_GEN_END: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (abort_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_clr   = abort_i || frame_go || (state_d != state_q);
    assign crc_upd   = !abort_i && step &&
                       (state_q == ST_CHK_DATA || state_q == ST_GEN_DATA);
    assign crc_shout = !abort_i && (state_q == ST_GEN_CRC);
    assign rx_en     = !abort_i && step && (state_q == ST_CHK_CRC);

    crc7_bit_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (step),
        .cnt_o (cnt)
    );

    crc7_lfsr #(.WIDTH(CRC_W), .TAPS(TAPS)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (abort_i || frame_go),
        .upd_i   (crc_upd),
        .din_i   (bit_i),
        .shout_i (crc_shout),
        .crc_o   (crc_calc)
    );

    crc7_rx_capture #(.WIDTH(CRC_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (abort_i || frame_go),
        .en_i    (rx_en),
        .din_i   (bit_i),
        .value_o (crc_rx)
    );

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid_o <= 1'b0;
            tx_bit_o   <= 1'b0;
            done_o     <= 1'b0;
            crc_ok_o   <= 1'b0;
            crc_err_o  <= 1'b0;
        end else if (abort_i) begin
            tx_valid_o <= 1'b0;
            tx_bit_o   <= 1'b0;
            done_o     <= 1'b0;
            crc_ok_o   <= 1'b0;
            crc_err_o  <= 1'b0;
        end else begin
            tx_valid_o <= 1'b0;
            tx_bit_o   <= 1'b0;
            done_o     <= 1'b0;
            crc_ok_o   <= 1'b0;
            crc_err_o  <= 1'b0;
            unique case (state_q)
                ST_GEN_DATA: begin
                    if (step) begin
                        tx_valid_o <= 1'b1;
                        tx_bit_o   <= bit_i;
                    end
                end
                ST_GEN_CRC: begin
                    tx_valid_o <= 1'b1;
                    tx_bit_o   <= crc_calc[CRC_W-1];
                end
                ST_GEN_END: begin
                    tx_valid_o <= 1'b1;
                    tx_bit_o   <= 1'b1;
                    done_o     <= 1'b1;
                end
                ST_CHK_END: begin
                    if (step) begin
                        done_o    <= 1'b1;
                        crc_ok_o  <= (crc_rx == crc_calc);
                        crc_err_o <= (crc_rx != crc_calc);
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/cmd_crc7_unit_chk.sv
module cmd_crc7_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic abort_i,
    input logic tx_valid_o,
    input logic tx_bit_o,
    input logic done_o,
    input logic crc_ok_o,
    input logic crc_err_o
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_ok_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok_o && crc_err_o));

    p_status_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok_o || crc_err_o) |-> done_o);

    p_check_done_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !tx_valid_o) |-> (crc_ok_o || crc_err_o));

    p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !(done_o || tx_valid_o || crc_ok_o || crc_err_o));

    p_end_bit_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && tx_valid_o) |-> tx_bit_o);

    p_gen_no_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> !(crc_ok_o || crc_err_o));
endmodule

bind cmd_crc7_unit cmd_crc7_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_i    (abort_i),
    .tx_valid_o (tx_valid_o),
    .tx_bit_o   (tx_bit_o),
    .done_o     (done_o),
    .crc_ok_o   (crc_ok_o),
    .crc_err_o  (crc_err_o)
);

// File: tb/cmd_crc7_unit_tb_top.sv
module cmd_crc7_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, mode_i = 1'b0, abort_i = 1'b0;
    logic bit_valid_i = 1'b0, bit_i = 1'b0;
    logic tx_valid_o, tx_bit_o, done_o, crc_ok_o, crc_err_o;

    int n_tests = 0;
    int n_fail  = 0;

    // monitor state
    logic [47:0] cap;
    int ncap = 0;
    int ndone = 0;
    int nok = 0;
    int nerr = 0;

    // payload / known CRC pairs
    localparam logic [46:0] VEC [4] = '{
        {40'h40_0000_0000, 7'h4A},
        {40'h48_0000_01AA, 7'h43},
        {40'h51_0000_0000, 7'h2A},
        {40'h77_0000_0000, 7'h32}
    };

    always #10 clk = ~clk; // 50 MHz

    cmd_crc7_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .abort_i(abort_i), .bit_valid_i(bit_valid_i), .bit_i(bit_i),
        .tx_valid_o(tx_valid_o), .tx_bit_o(tx_bit_o), .done_o(done_o),
        .crc_ok_o(crc_ok_o), .crc_err_o(crc_err_o)
    );

    always @(negedge clk) begin
        if (tx_valid_o) begin
            cap  = {cap[46:0], tx_bit_o};
            ncap = ncap + 1;
        end
        if (done_o)    ndone = ndone + 1;
        if (crc_ok_o)  nok   = nok + 1;
        if (crc_err_o) nerr  = nerr + 1;
    end

    // long division reference: message * x^7 mod (x^7 + x^3 + 1)
    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [46:0] r;
        r = {m, 7'b0};
        for (int i = 46; i >= 7; i--) begin
            if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
        end
        return r[6:0];
    endfunction

    task automatic check(input bit cond, input string req, input longint act, input longint exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        cap = '0; ncap = 0; ndone = 0; nok = 0; nerr = 0;
    endtask

    task automatic start_frame(input logic m);
        start_i = 1'b1; mode_i = m;
        @(negedge clk);
        start_i = 1'b0; mode_i = 1'b0;
    endtask

    task automatic send_bit(input logic b, input int gap);
        bit_valid_i = 1'b1; bit_i = b;
        @(negedge clk);
        bit_valid_i = 1'b0; bit_i = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_gen(input logic [39:0] p, input logic [6:0] exp, input int gap, input string req);
        clr_mon();
        start_frame(1'b1);
        for (int i = 39; i >= 0; i--) send_bit(p[i], gap);
        repeat (12) @(negedge clk);
        check(ncap == 48, req, ncap, 48);
        check(cap[47:8] == p && cap[7:1] == exp && cap[0] == 1'b1, req, cap, {p, exp, 1'b1});
        check(ndone == 1 && nok == 0 && nerr == 0, "R10", {ndone, nok, nerr}, 1);
    endtask

    task automatic run_chk(input logic [39:0] p, input logic [6:0] c, input logic endb,
                           input int gap, input bit exp_ok, input string req);
        clr_mon();
        start_frame(1'b0);
        for (int i = 39; i >= 0; i--) send_bit(p[i], gap);
        for (int i = 6; i >= 0; i--) send_bit(c[i], gap);
        send_bit(endb, gap);
        repeat (4) @(negedge clk);
        check(ndone == 1 && nok == int'(exp_ok) && nerr == int'(!exp_ok) && ncap == 0,
              req, {ndone, nok, nerr}, {1, int'(exp_ok), int'(!exp_ok)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [39:0] p;
        logic [6:0]  c;
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check({tx_valid_o, tx_bit_o, done_o, crc_ok_o, crc_err_o} == 5'b0, "R9",
              {tx_valid_o, tx_bit_o, done_o, crc_ok_o, crc_err_o}, 0);

        // vector table: R1 reference, R3 generate, R4 match, R5 mismatch
        for (int k = 0; k < 4; k++) begin
            p = VEC[k][46:7];
            c = VEC[k][6:0];
            check(ref_crc(p) == c, "R1", ref_crc(p), c);
            run_gen(p, c, 0, "R3");
            run_chk(p, c, 1'b1, 0, 1'b1, "R4");
            run_chk(p, c ^ 7'h01, 1'b1, 0, 1'b0, "R5");
        end

        // R1 extra payload patterns against long division
        run_gen(40'hFF_FFFF_FFFF, ref_crc(40'hFF_FFFF_FFFF), 0, "R1");
        run_gen(40'h6A_5A3C_C381, ref_crc(40'h6A_5A3C_C381), 0, "R1");

        // R2 gaps between strobed bits
        run_gen(40'h4D_1234_ABCD, ref_crc(40'h4D_1234_ABCD), 2, "R2");
        run_chk(40'h4D_1234_ABCD, ref_crc(40'h4D_1234_ABCD), 1'b1, 1, 1'b1, "R2");

        // R6 end bit of 0 in check mode
        run_chk(40'h51_0000_0000, 7'h2A, 1'b0, 0, 1'b1, "R6");

        // R5 single-bit payload corruption
        run_chk(40'h40_0000_0001, 7'h4A, 1'b1, 0, 1'b0, "R5");

        // R8 start with other mode mid-frame is ignored
        clr_mon();
        p = 40'h48_0000_01AA;
        start_frame(1'b0);
        for (int i = 39; i >= 20; i--) send_bit(p[i], 0);
        start_frame(1'b1);
        for (int i = 19; i >= 0; i--) send_bit(p[i], 0);
        for (int i = 6; i >= 0; i--) send_bit(7'h43 >> i, 0);
        send_bit(1'b1, 0);
        repeat (4) @(negedge clk);
        check(ndone == 1 && nok == 1 && ncap == 0, "R8", {ndone, nok, ncap}, {1, 1, 0});

        // R7 abort in check data phase, then clean frame
        clr_mon();
        start_frame(1'b0);
        for (int i = 0; i < 20; i++) send_bit(1'b1, 0);
        abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
        for (int i = 0; i < 27; i++) send_bit(1'b1, 0);
        repeat (4) @(negedge clk);
        check(ndone == 0 && nok == 0 && nerr == 0, "R7", ndone, 0);
        run_chk(40'h77_0000_0000, 7'h32, 1'b1, 0, 1'b1, "R7");

        // R7 abort during generated CRC tail
        clr_mon();
        p = 40'h77_0000_0000;
        start_frame(1'b1);
        for (int i = 39; i >= 0; i--) send_bit(p[i], 0);
        @(negedge clk);
        abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
        @(negedge clk);
        snap = ncap;
        repeat (10) @(negedge clk);
        check(ncap == snap && ncap < 48 && ndone == 0, "R7", {ncap, ndone}, {snap, 0});
        // R8 register cleared at new start after aborted frame
        run_gen(40'h40_0000_0000, 7'h4A, 0, "R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule